// File: doc/BRIEF.md
# Sensor Serial Port with Command Register

This block is the digital face of a sampled sensor. It is a 16-bit, full-duplex serial slave. An active-low select frames each transfer. The serial clock idles high, and both directions move on its falling edge. Four 12-bit readings arrive on parallel inputs: angular rate, temperature and two auxiliary channels. When select falls, the block latches the reading chosen by its command register. It then returns a word made of two zero bits, the 2-bit source code and the 12-bit reading, sent MSB first.

The command shifted in during the same frame can rewrite the command register. That register holds the source selection and the output format. The format is either offset binary, with the null reading at 2048, or twos complement. The register changes only when a frame runs to exactly 16 falling clock edges. A frame with fewer edges changes nothing. The word returned in a frame always reflects the settings that were in force before that frame's command.

The serial pins are asynchronous to the block. They are brought into the fast system clock through synchronizer chains, and their edges are found there. The serial clock must therefore be several system clocks long per phase.

Top module: `sensor_spi_port`

## Requirements
- R1: While select is high, the drive enable stays low, and serial clock and data activity leave the command register unchanged.
- R2: Command bits are taken on serial clock falling edges, MSB first. Bit 15 set writes the register. Bit 15 clear leaves it as it was, whatever the other bits hold.
- R3: Command bits 11:10 select the source: 00 rate, 01 temperature, 10 auxiliary A, 11 auxiliary B. The returned word carries the same code in bits 13:12.
- R4: Command bit 4 selects the format. With 1 the reading is returned as given (offset binary, null 2048). With 0 the top bit of the reading is inverted, which gives twos complement; a reading of 2047 is returned as 0xFFF.
- R5: The register updates only after the 16th falling edge of a frame. A frame with 15 or fewer edges leaves it unchanged.
- R6: The word is {2'b00, source, data}, MSB first. Bit 15 is driven when select falls, and each following bit appears after each falling edge. The drive enable drops after the 16th edge.
- R7: The reading is latched when select falls. Later changes on the parallel inputs do not alter that frame's word.
- R8: The hold indicator rises when select falls and drops on the 14th falling edge, or when select rises, whichever comes first.
- R9: The word returned in a writing frame uses the source and format from before that frame.
- R10: A write is still applied when bit 14 is 1, bits 9:8 are not 11, or bit 5 is 1. Any of these sets a sticky fault flag. Frames with bit 15 clear, and don't-care bits (13:12, 7:6, 3:0), never set it.
- R11: Reset selects the rate source in twos complement and clears the drive enable, the hold indicator and the fault flag.
- R12: Falling edges after the 16th in a frame are ignored. The command is formed from the first 16 bits only, and the drive stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idles high, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_in | input | 1 | Serial command input |
| rate_raw | input | 12 | Rate reading, offset binary |
| temp_raw | input | 12 | Temperature reading, offset binary |
| aux_a_raw | input | 12 | Auxiliary A reading, offset binary |
| aux_b_raw | input | 12 | Auxiliary B reading, offset binary |
| ser_out | output | 1 | Serial data output, meaningful while enabled |
| ser_out_en | output | 1 | Output drive enable; low means high-impedance |
| sample_hold | output | 1 | High while the latched reading is held |
| cmd_fault | output | 1 | Sticky flag for a write with bad constant bits |

## Verification
Frames are sent with each of the four source codes under both formats. This separates a wrong source decode from a wrong format transform. A reading of 2047 in twos complement tells an inverted top bit from a two's negation. Frames of 10, 15 and 18 edges, plus clock toggling while deselected, show whether commit hangs on the exact edge count and on select. Changing the readings in mid-frame shows whether the sample is latched at the select edge. Commands with junk in the don't-care bits or with broken constant bits separate the fault flag from the write path.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

    localparam int FRAME_BITS = 16;
    localparam int SAMPLE_W   = 12;
    localparam int SRC_W      = 2;
    localparam int LEAD_W     = FRAME_BITS - SRC_W - SAMPLE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int HOLD_EDGE  = 14;

    // command bit positions decoded by the control logic
    localparam int B_WR     = 15;
    localparam int B_ZERO_A = 14;
    localparam int B_SRC_HI = 11;
    localparam int B_SRC_LO = 10;
    localparam int B_ONE_HI = 9;
    localparam int B_ONE_LO = 8;
    localparam int B_ZERO_B = 5;
    localparam int B_FMT    = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_RATE  = 2'b00,
        SRC_TEMP  = 2'b01,
        SRC_AUX_A = 2'b10,
        SRC_AUX_B = 2'b11
    } src_e;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;

    typedef struct packed {
        src_e src;
        fmt_e fmt;
    } cfg_t;

    typedef struct packed {
        logic wr;
        logic legal;
        src_e src;
        fmt_e fmt;
    } cmd_view_t;

    localparam cfg_t CFG_RESET = '{src: SRC_RATE, fmt: FMT_TWOS};

    function automatic cmd_view_t view_cmd(logic [FRAME_BITS-1:0] w);
        cmd_view_t v;
        v.wr    = w[B_WR];
        v.legal = !w[B_ZERO_A] && (w[B_ONE_HI:B_ONE_LO] == 2'b11) && !w[B_ZERO_B];
        v.src   = src_e'(w[B_SRC_HI:B_SRC_LO]);
        v.fmt   = fmt_e'(w[B_FMT]);
        return v;
    endfunction

    function automatic logic [SAMPLE_W-1:0] encode(logic [SAMPLE_W-1:0] raw, fmt_e f);
        logic [SAMPLE_W-1:0] msb_flip;
        msb_flip = {1'b1, {(SAMPLE_W-1){1'b0}}};
        return (f == FMT_OFFSET) ? raw : (raw ^ msb_flip);
    endfunction

    function automatic logic [FRAME_BITS-1:0] make_word(src_e s, logic [SAMPLE_W-1:0] d);
        return {{LEAD_W{1'b0}}, s, d};
    endfunction

endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= (chain_q << 1) | STAGES'(async_i[b]);
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sspi_frame.sv
module sspi_frame
    import sspi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_s,
    input  logic                  seln_s,
    input  logic                  din_s,
    input  logic [FRAME_BITS-1:0] load_word,
    output logic                  sel_fall,
    output logic                  oe,
    output logic                  dout,
    output logic                  hold,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] rx_word
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_EDGE - 1);

    logic                  sclk_d, seln_d;
    logic                  active_q, hold_q, commit_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] tx_sr, rx_sr;
    logic                  sel_rise, edge_take;

    assign sel_fall  = seln_d & ~seln_s;
    assign sel_rise  = ~seln_d & seln_s;
    assign edge_take = sclk_d & ~sclk_s & active_q & (cnt_q != CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b1;
            seln_d   <= 1'b1;
            active_q <= 1'b0;
            hold_q   <= 1'b0;
            commit_q <= 1'b0;
            cnt_q    <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else begin
            sclk_d   <= sclk_s;
            seln_d   <= seln_s;
            commit_q <= 1'b0;
            if (sel_fall) begin
                active_q <= 1'b1;
                hold_q   <= 1'b1;
                cnt_q    <= '0;
                tx_sr    <= load_word;
            end else if (sel_rise) begin
                active_q <= 1'b0;
                hold_q   <= 1'b0;
            end else if (edge_take) begin
                cnt_q <= cnt_q + CNT_W'(1);
                tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                rx_sr <= {rx_sr[FRAME_BITS-2:0], din_s};
                if (cnt_q == CNT_HOLD) hold_q <= 1'b0;
                if (cnt_q == CNT_LAST) commit_q <= 1'b1;
            end
        end
    end

    assign oe      = active_q & (cnt_q != CNT_FULL);
    assign dout    = tx_sr[FRAME_BITS-1];
    assign hold    = hold_q;
    assign commit  = commit_q;
    assign rx_word = rx_sr;

    // R12: the edge count never passes the frame length
    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL) else $error("edge count overflow");

    // R12: no further shifting once the frame is full
    p_rx_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_FULL) |=> $stable(rx_sr)) else $error("shift after 16th edge");

    // R5: commit pulse only with a complete frame
    p_commit_full_r5: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> (cnt_q == CNT_FULL)) else $error("commit on short frame");

    // R1: settled deselect means no drive
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (seln_s && seln_d) |-> !oe) else $error("drive while deselected");

    // R6: first driven bit is a zero
    p_first_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !dout) else $error("leading bit not zero");

    // R8: hold starts with select falling
    p_hold_start_r8: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> hold_q) else $error("hold not raised");

endmodule

// File: rtl/sspi_ctrl.sv
module sspi_ctrl
    import sspi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  cmd_view_t cmd,
    output cfg_t      cfg,
    output logic      fault
);

    cfg_t cfg_q;
    logic fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            fault_q <= 1'b0;
        end else if (commit && cmd.wr) begin
            cfg_q.src <= cmd.src;
            cfg_q.fmt <= cmd.fmt;
            if (!cmd.legal) fault_q <= 1'b1;
        end
    end

    assign cfg   = cfg_q;
    assign fault = fault_q;

    // R5: settings move only on a commit pulse
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg_q)) else $error("config moved without commit");

    // R2: a read frame leaves settings alone
    p_read_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (commit && !cmd.wr) |=> $stable(cfg_q)) else $error("read frame wrote config");

    // R10: the fault flag is sticky
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q) else $error("fault flag cleared");

    // R10: a read frame never raises the flag
    p_read_no_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (!fault_q && !(commit && cmd.wr)) |=> !fault_q) else $error("spurious fault");

endmodule

// File: rtl/sspi_src.sv
module sspi_src
    import sspi_pkg::*;
(
    input  logic [SAMPLE_W-1:0]   rate_raw,
    input  logic [SAMPLE_W-1:0]   temp_raw,
    input  logic [SAMPLE_W-1:0]   aux_a_raw,
    input  logic [SAMPLE_W-1:0]   aux_b_raw,
    input  cfg_t                  cfg,
    output logic [FRAME_BITS-1:0] word
);

    localparam int N_SRC = 1 << SRC_W;

    logic [SAMPLE_W-1:0] bank [N_SRC];
    logic [SAMPLE_W-1:0] picked;

    assign bank[SRC_RATE]  = rate_raw;
    assign bank[SRC_TEMP]  = temp_raw;
    assign bank[SRC_AUX_A] = aux_a_raw;
    assign bank[SRC_AUX_B] = aux_b_raw;

    assign picked = bank[cfg.src];
    assign word   = make_word(cfg.src, encode(picked, cfg.fmt));

endmodule

// File: rtl/sensor_spi_port.sv
module sensor_spi_port
    import sspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_sel_n,
    input  logic                ser_in,
    input  logic [SAMPLE_W-1:0] rate_raw,
    input  logic [SAMPLE_W-1:0] temp_raw,
    input  logic [SAMPLE_W-1:0] aux_a_raw,
    input  logic [SAMPLE_W-1:0] aux_b_raw,
    output logic                ser_out,
    output logic                ser_out_en,
    output logic                sample_hold,
    output logic                cmd_fault
);

    logic [2:0]            pins_s;
    logic                  sel_fall, commit;
    logic [FRAME_BITS-1:0] src_word, rx_word;
    cmd_view_t             cmd_view;
    cfg_t                  cfg;

    sspi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_clk, ser_sel_n, ser_in}),
        .sync_o  (pins_s)
    );

    sspi_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .seln_s    (pins_s[1]),
        .din_s     (pins_s[0]),
        .load_word (src_word),
        .sel_fall  (sel_fall),
        .oe        (ser_out_en),
        .dout      (ser_out),
        .hold      (sample_hold),
        .commit    (commit),
        .rx_word   (rx_word)
    );

    assign cmd_view = view_cmd(rx_word);

    sspi_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .cmd    (cmd_view),
        .cfg    (cfg),
        .fault  (cmd_fault)
    );

    sspi_src u_src (
        .rate_raw  (rate_raw),
        .temp_raw  (temp_raw),
        .aux_a_raw (aux_a_raw),
        .aux_b_raw (aux_b_raw),
        .cfg       (cfg),
        .word      (src_word)
    );

    // R7: the word loads at the select edge, so a new frame starts driven
    p_load_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> ser_out_en) else $error("frame did not start");

endmodule

// File: tb/sensor_spi_port_tb_top.sv
module sensor_spi_port_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        sck, seln, sin;
    logic [11:0] s_rate, s_temp, s_auxa, s_auxb;
    logic        ser_out, oe, hold, fault;

    sensor_spi_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (sck),
        .ser_sel_n  (seln),
        .ser_in     (sin),
        .rate_raw   (s_rate),
        .temp_raw   (s_temp),
        .aux_a_raw  (s_auxa),
        .aux_b_raw  (s_auxb),
        .ser_out    (ser_out),
        .ser_out_en (oe),
        .sample_hold(hold),
        .cmd_fault  (fault)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic       exp_oe = 1'b0, exp_bit = 1'b0, exp_hold = 1'b0, exp_fault = 1'b0;
    logic [1:0] m_src = 2'b00;
    logic       m_fmt = 1'b0;
    int         settle = 0;
    bit         chk_on = 1'b0;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] coded(input logic [11:0] raw, input logic fmt);
        return fmt ? raw : {~raw[11], raw[10:0]};
    endfunction

    function automatic logic [11:0] sample_of(input logic [1:0] s);
        case (s)
            2'b00:   return s_rate;
            2'b01:   return s_temp;
            2'b10:   return s_auxa;
            default: return s_auxb;
        endcase
    endfunction

    // per-clock comparison against the model, once the synchronizers have settled
    always @(negedge clk) begin
        if (settle < 1000) settle++;
        if (chk_on && settle >= 6) begin
            chk("R6 drive enable", {15'd0, oe}, {15'd0, exp_oe});
            if (exp_oe) chk("R6 serial bit", {15'd0, ser_out}, {15'd0, exp_bit});
            chk("R8 hold indicator", {15'd0, hold}, {15'd0, exp_hold});
            chk("R10 fault flag", {15'd0, fault}, {15'd0, exp_fault});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_frame(input logic [15:0] cmd, input int edges, input string req, input bit poke = 1'b0);
        logic [15:0] word, got;
        got  = '0;
        word = {2'b00, m_src, coded(sample_of(m_src), m_fmt)};
        tick(1);
        seln = 1'b0; settle = 0;
        exp_oe = 1'b1; exp_bit = word[15]; exp_hold = 1'b1;
        tick(10);
        got[15] = ser_out;
        if (poke) begin
            s_rate = ~s_rate; s_temp = ~s_temp; s_auxa = ~s_auxa; s_auxb = ~s_auxb;
        end
        for (int i = 0; i < edges; i++) begin
            sin = (i < 16) ? cmd[15-i] : 1'b1;
            tick(10);
            sck = 1'b0; settle = 0;
            if (i + 1 < 16) exp_bit = word[15-(i+1)];
            else exp_oe = 1'b0;
            if (i + 1 == 14) exp_hold = 1'b0;
            if (i + 1 == 16 && cmd[15]) begin
                m_src = cmd[11:10];
                m_fmt = cmd[4];
                if (cmd[14] || cmd[9:8] != 2'b11 || cmd[5]) exp_fault = 1'b1;
            end
            tick(10);
            if (i + 1 < 16) got[15-(i+1)] = ser_out;
            sck = 1'b1; settle = 0;
        end
        tick(10);
        seln = 1'b1; settle = 0;
        exp_oe = 1'b0; exp_hold = 1'b0;
        tick(12);
        if (edges >= 16) chk({req, " returned word"}, got, word);
    endtask

    task automatic idle_toggle(input logic [15:0] cmd);
        for (int i = 0; i < 16; i++) begin
            sin = cmd[15-i];
            tick(6);
            sck = 1'b0;
            tick(6);
            sck = 1'b1;
        end
        tick(10);
    endtask

    task automatic do_reset();
        chk_on = 1'b0;
        rst = 1'b1;
        tick(4);
        rst = 1'b0; settle = 0;
        m_src = 2'b00; m_fmt = 1'b0;
        exp_oe = 1'b0; exp_hold = 1'b0; exp_fault = 1'b0;
        chk_on = 1'b1;
        tick(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; sck = 1'b1; seln = 1'b1; sin = 1'b0;
        s_rate = 12'h9AB; s_temp = 12'h123; s_auxa = 12'hF00; s_auxb = 12'h800;
        do_reset();
        chk("R11 enable after reset", {15'd0, oe}, 16'd0);
        chk("R11 hold after reset", {15'd0, hold}, 16'd0);
        chk("R11 fault after reset", {15'd0, fault}, 16'd0);

        do_frame(16'h0000, 16, "R11 default rate twos");
        do_frame(16'h8710, 16, "R9 old settings in writing frame");
        do_frame(16'h0000, 16, "R3 R4 temperature offset");
        do_frame(16'h8B00, 16, "R9 second write");
        do_frame(16'h0000, 16, "R3 aux A twos");
        do_frame(16'hBFDF, 16, "R9 write with don't-care bits");
        do_frame(16'h0000, 16, "R3 aux B offset");
        chk("R10 don't-care bits raise no fault", {15'd0, fault}, 16'd0);

        do_frame(16'h7FFF, 16, "R2 read frame with junk");
        do_frame(16'h0000, 16, "R2 settings kept after read");
        chk("R10 read frame raises no fault", {15'd0, fault}, 16'd0);

        do_frame(16'h8300, 10, "R5 ten-edge frame");
        do_frame(16'h8300, 15, "R5 fifteen-edge frame");
        do_frame(16'h0000, 16, "R5 settings kept after short frames");

        do_frame(16'h8710, 18, "R12 eighteen-edge frame");
        do_frame(16'h0000, 16, "R12 first sixteen bits used");

        do_frame(16'h0000, 16, "R7 reading latched at select fall", 1'b1);

        idle_toggle(16'h8300);
        do_frame(16'h0000, 16, "R1 settings kept while deselected");

        s_rate = 12'h7FF;
        do_frame(16'h8300, 16, "R9 switch to rate twos");
        do_frame(16'h0000, 16, "R4 reading 2047 in twos");
        chk("R4 twos minus one", {4'd0, coded(12'h7FF, 1'b0)}, 16'h0FFF);

        do_frame(16'hC310, 16, "R10 bit 14 violated");
        chk("R10 fault set", {15'd0, fault}, 16'd1);
        do_frame(16'h0000, 16, "R10 bad write still applied");
        chk("R10 fault sticky", {15'd0, fault}, 16'd1);

        do_reset();
        chk("R11 reset clears fault", {15'd0, fault}, 16'd0);
        do_frame(16'h8230, 16, "R10 bits 9:8 and 5 violated");
        chk("R10 fault set again", {15'd0, fault}, 16'd1);
        do_frame(16'h0000, 16, "R10 rate offset after bad write");

        tick(10);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule